// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a 32-bit status register that tells software what caused the most recent reset. Ten sources each own one sticky flag: a cold-reset request and a warm-reset request from the system manager, a last-power-on indicator, five watchdog warm resets, a debug reset and a debug-access-port reset. A one-cycle event pulse from a source sets its flag on the next clock edge. The flag then stays set until software clears it by writing a 1 to that bit.

The block takes three synchronous active-low resets: power-on, cold and warm. Each flag belongs to one reset domain. Most flags are cleared by a cold reset. The system-manager cold flag, the last-power-on flag, the debug flag and the debug-access-port flag survive a cold reset and return to their reset values only at power-on. A warm reset clears nothing, so software can still see the cause of a warm reset after it. The last-power-on flag powers up set.

Top module: `rstcause_status`

## Requirements
- R1: While power-on reset is asserted, and on the cycle after it, rd_data reads 0x0000_0004. Only the last-power-on flag (bit 2) is set.
- R2: An event pulse sets its flag at the next clock edge. The bit positions are: cold request bit 0, warm request bit 1, last power-on bit 2, watchdogs 0 to 4 at bits 16 to 20, debug reset bit 24, debug access port bit 25.
- R3: A flag stays set after its event pulse ends.
- R4: A write with wr_en high clears every implemented flag whose wr_data bit is 1. Flags whose wr_data bit is 0 are left unchanged.
- R5: Bits 3 to 15, 21 to 23 and 26 to 31 always read 0, and writes to them have no effect.
- R6: A cold reset clears bits 1 and 16 to 20. It leaves bits 0, 2, 24 and 25 at their previous values, including a last-power-on flag that software has already cleared.
- R7: A power-on reset returns every flag to its reset value, whatever the prior state.
- R8: A warm reset changes no flag.
- R9: When an event and a clearing write hit the same bit in the same cycle, the flag ends at 1. Other bits cleared by the same write still clear.
- R10: Reads have no side effects. With no event, write or reset, rd_data holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_rst_n | input | 1 | Power-on reset, synchronous, active low |
| cold_rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| evt_cold_req | input | 1 | Pulse: system manager requested a cold reset |
| evt_warm_req | input | 1 | Pulse: system manager requested a warm reset |
| evt_last_por | input | 1 | Pulse: system manager's last reset was a power-on |
| evt_wdog | input | 5 | Pulses: watchdog n triggered a warm reset (bit n) |
| evt_debug | input | 1 | Pulse: debug reset asserted |
| evt_dap | input | 1 | Pulse: debug access port was reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data; a 1 clears the matching flag |
| rd_data | output | 32 | Current flag values |

## Verification
The bench targets the retention split at a cold reset. It clears the last-power-on flag and then applies a cold reset. A design with the wrong domain on that bit would bring it back to 1 or drop a retained flag. The bench also asserts a warm reset with every flag set, which exposes any flag wrongly placed in the warm domain. It fires an event and a clear at the same bit in the same cycle: a clear-priority design would read 0 there. Writes of all-ones to the reserved bits and a final power-on reset check that reserved bits stay 0 and that bit 2 powers up set.

// File: rtl/rstcause_pkg.sv
// rstcause_pkg: bit positions, reset domains and derived masks shared by the
// reset cause status register and its checker.
package rstcause_pkg;

    localparam int REG_W     = 32;
    localparam int NWDOG     = 5;
    localparam int POS_COLD  = 0;
    localparam int POS_WARM  = 1;
    localparam int POS_LPOR  = 2;
    localparam int POS_WDOG0 = 16;
    localparam int POS_DBG   = 24;
    localparam int POS_DAP   = 25;

    // Reset domain of a flag: which reset returns it to its reset value.
    typedef enum logic [1:0] {
        DOM_POR  = 2'd0,
        DOM_COLD = 2'd1,
        DOM_WARM = 2'd2
    } dom_e;

    // Mask of bits that hold a flag.
    function automatic logic [REG_W-1:0] calc_impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[POS_COLD] = 1'b1;
        m[POS_WARM] = 1'b1;
        m[POS_LPOR] = 1'b1;
        for (int i = 0; i < NWDOG; i++) m[POS_WDOG0+i] = 1'b1;
        m[POS_DBG] = 1'b1;
        m[POS_DAP] = 1'b1;
        return m;
    endfunction

    // Mask of flags that only a power-on reset clears.
    function automatic logic [REG_W-1:0] calc_por_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[POS_COLD] = 1'b1;
        m[POS_LPOR] = 1'b1;
        m[POS_DBG]  = 1'b1;
        m[POS_DAP]  = 1'b1;
        return m;
    endfunction

    // Register value right after a power-on reset.
    function automatic logic [REG_W-1:0] calc_rst_value();
        logic [REG_W-1:0] m;
        m = '0;
        m[POS_LPOR] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MASK = calc_impl_mask();
    localparam logic [REG_W-1:0] POR_MASK  = calc_por_mask();
    localparam logic [REG_W-1:0] COLD_MASK = IMPL_MASK & ~POR_MASK;
    localparam logic [REG_W-1:0] RSVD_MASK = ~IMPL_MASK;
    localparam logic [REG_W-1:0] RST_VALUE = calc_rst_value();

    // Domain of bit b; no flag is placed in the warm domain.
    function automatic dom_e flag_dom(int b);
        if (POR_MASK[b]) return DOM_POR;
        return DOM_COLD;
    endfunction

endpackage

// File: rtl/rstcause_flag.sv
// rstcause_flag: one sticky status bit with its own reset domain.
// Assumes the resets are synchronous to clk and active low. Power-on beats
// cold, cold beats warm. A reset only touches the bit if the domain includes
// it. Below the resets, a set beats a clear. A cell with IMPLEMENTED = 0
// is a reserved bit that stays at 0.
module rstcause_flag
    import rstcause_pkg::*;
#(
    parameter bit   IMPLEMENTED = 1'b1,
    parameter bit   RST_VAL     = 1'b0,
    parameter dom_e DOM         = DOM_COLD
) (
    input  logic clk,
    input  logic por_rst_n,
    input  logic cold_rst_n,
    input  logic warm_rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    localparam bit COLD_HITS = (DOM != DOM_POR);
    localparam bit WARM_HITS = (DOM == DOM_WARM);

    logic q;

    // Update the flag: resets by domain, then set, then clear.
    always_ff @(posedge clk) begin
        if (!por_rst_n)
            q <= RST_VAL;
        else if (!cold_rst_n && COLD_HITS)
            q <= RST_VAL;
        else if (!warm_rst_n && WARM_HITS)
            q <= RST_VAL;
        else if (IMPLEMENTED && set_i)
            q <= 1'b1;
        else if (IMPLEMENTED && clr_i)
            q <= 1'b0;
    end

    assign q_o = IMPLEMENTED ? q : 1'b0;

endmodule

// File: rtl/rstcause_setmap.sv
// rstcause_setmap: places each source's event pulse on its register bit.
// Assumes the pulses are single-cycle and synchronous to the register clock.
// Reserved positions stay 0.
module rstcause_setmap
    import rstcause_pkg::*;
(
    input  logic             evt_cold_req,
    input  logic             evt_warm_req,
    input  logic             evt_last_por,
    input  logic [NWDOG-1:0] evt_wdog,
    input  logic             evt_debug,
    input  logic             evt_dap,
    output logic [REG_W-1:0] set_vec
);

    logic [REG_W-1:0] wdog_bits;

    // Watchdog pulses go to consecutive bits starting at the first watchdog slot.
    for (genvar i = 0; i < REG_W; i++) begin : g_wdog
        if (i >= POS_WDOG0 && i < POS_WDOG0 + NWDOG) begin : g_on
            assign wdog_bits[i] = evt_wdog[i-POS_WDOG0];
        end else begin : g_off
            assign wdog_bits[i] = 1'b0;
        end
    end

    // Combine the single-bit sources with the watchdog field.
    always_comb begin
        set_vec           = wdog_bits;
        set_vec[POS_COLD] = evt_cold_req;
        set_vec[POS_WARM] = evt_warm_req;
        set_vec[POS_LPOR] = evt_last_por;
        set_vec[POS_DBG]  = evt_debug;
        set_vec[POS_DAP]  = evt_dap;
    end

endmodule

// File: rtl/rstcause_bank.sv
// rstcause_bank: the full row of flag cells. Each bit takes its
// implementation, reset value and domain from the package masks.
// Assumes set and clear vectors are already aligned to register bits.
module rstcause_bank
    import rstcause_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             cold_rst_n,
    input  logic             warm_rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] flags
);

    // One cell per bit, configured from the package masks.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        localparam bit   IMPL = IMPL_MASK[b];
        localparam bit   RV   = RST_VALUE[b];
        localparam dom_e DM   = flag_dom(b);
        rstcause_flag #(
            .IMPLEMENTED (IMPL),
            .RST_VAL     (RV),
            .DOM         (DM)
        ) u_flag (
            .clk        (clk),
            .por_rst_n  (por_rst_n),
            .cold_rst_n (cold_rst_n),
            .warm_rst_n (warm_rst_n),
            .set_i      (set_vec[b]),
            .clr_i      (clr_vec[b]),
            .q_o        (flags[b])
        );
    end

endmodule

// File: rtl/rstcause_status.sv
// rstcause_status: reset cause status register, top level.
// Records which source requested the last reset. Software clears flags by
// writing 1s. Reads come straight from the flags and have no side effects.
// Assumes all inputs are synchronous to clk and all resets are active low.
module rstcause_status
    import rstcause_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             cold_rst_n,
    input  logic             warm_rst_n,
    input  logic             evt_cold_req,
    input  logic             evt_warm_req,
    input  logic             evt_last_por,
    input  logic [NWDOG-1:0] evt_wdog,
    input  logic             evt_debug,
    input  logic             evt_dap,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    rstcause_setmap u_map (
        .evt_cold_req (evt_cold_req),
        .evt_warm_req (evt_warm_req),
        .evt_last_por (evt_last_por),
        .evt_wdog     (evt_wdog),
        .evt_debug    (evt_debug),
        .evt_dap      (evt_dap),
        .set_vec      (set_vec)
    );

    // Write-one-to-clear: gate the write data with the strobe.
    assign clr_vec = wr_en ? wr_data : '0;

    rstcause_bank u_bank (
        .clk        (clk),
        .por_rst_n  (por_rst_n),
        .cold_rst_n (cold_rst_n),
        .warm_rst_n (warm_rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .flags      (rd_data)
    );

endmodule

// File: rtl/rstcause_status_chk.sv
// rstcause_status_chk: timing properties of the reset cause register, bound
// to the top. Uses a live flag so that no check fires before the first edge.
module rstcause_status_chk
    import rstcause_pkg::*;
(
    input logic             clk,
    input logic             por_rst_n,
    input logic             cold_rst_n,
    input logic             warm_rst_n,
    input logic [REG_W-1:0] set_vec,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data
);

    logic live = 1'b0;

    // Mark that at least one edge has passed.
    always_ff @(posedge clk) live <= 1'b1;

    // R7
    por_value_chk: assert property (@(posedge clk) disable iff (!live)
        !por_rst_n |=> rd_data == RST_VALUE);

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!live)
        (por_rst_n && cold_rst_n && (set_vec != '0))
        |=> ((rd_data & $past(set_vec)) == $past(set_vec)));

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!live)
        (por_rst_n && wr_en && (set_vec == '0))
        |=> ((rd_data & $past(wr_data)) == '0));

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!live)
        (rd_data & RSVD_MASK) == '0);

    // R6
    cold_split_chk: assert property (@(posedge clk) disable iff (!live)
        (por_rst_n && !cold_rst_n && !wr_en && (set_vec == '0))
        |=> ((rd_data & COLD_MASK) == '0) &&
            ((rd_data & POR_MASK) == ($past(rd_data) & POR_MASK)));

    // R8, R10
    hold_chk: assert property (@(posedge clk) disable iff (!live)
        (por_rst_n && cold_rst_n && !wr_en && (set_vec == '0))
        |=> $stable(rd_data));

endmodule

bind rstcause_status rstcause_status_chk u_chk (
    .clk        (clk),
    .por_rst_n  (por_rst_n),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .set_vec    (set_vec),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data)
);

// File: tb/rstcause_status_test.sv
// Bench for rstcause_status: a vector table walked by one loop, then directed
// reset-domain tests. Inputs change at the falling edge. Results are read at
// the next falling edge, one rising edge later.
module rstcause_status_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // evt bits: [9] dap, [8] debug, [7:3] wdog4..0, [2] last por, [1] warm, [0] cold
    typedef struct packed {
        logic [3:0]  req;
        logic [9:0]  evt;
        logic        wr;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  10'h001, 1'b0, 32'h0000_0000, 32'h0000_0005}, // R2 cold request bit 0
        '{4'd3,  10'h000, 1'b0, 32'h0000_0000, 32'h0000_0005}, // R3 sticky
        '{4'd2,  10'h002, 1'b0, 32'h0000_0000, 32'h0000_0007}, // R2 warm request bit 1
        '{4'd2,  10'h088, 1'b0, 32'h0000_0000, 32'h0011_0007}, // R2 wdog0 bit16, wdog4 bit20
        '{4'd2,  10'h300, 1'b0, 32'h0000_0000, 32'h0311_0007}, // R2 debug bit24, dap bit25
        '{4'd4,  10'h000, 1'b1, 32'h0000_0001, 32'h0311_0006}, // R4 clear bit 0
        '{4'd4,  10'h000, 1'b1, 32'h0000_0000, 32'h0311_0006}, // R4 zeros leave flags
        '{4'd5,  10'h000, 1'b1, 32'hFCE0_FFF8, 32'h0311_0006}, // R5 reserved writes ignored
        '{4'd2,  10'h070, 1'b0, 32'h0000_0000, 32'h031F_0006}, // R2 wdog1..3
        '{4'd9,  10'h008, 1'b1, 32'h0001_0000, 32'h031F_0006}, // R9 set wins
        '{4'd4,  10'h000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 clear all
        '{4'd2,  10'h004, 1'b0, 32'h0000_0000, 32'h0000_0004}, // R2 last por bit 2
        '{4'd9,  10'h002, 1'b1, 32'h0000_0004, 32'h0000_0002}  // R9 clear other bit, set own
    };

    logic        clk = 1'b0;
    logic        por_rst_n, cold_rst_n, warm_rst_n;
    logic        evt_cold_req, evt_warm_req, evt_last_por, evt_debug, evt_dap;
    logic [4:0]  evt_wdog;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstcause_status uut (
        .clk          (clk),
        .por_rst_n    (por_rst_n),
        .cold_rst_n   (cold_rst_n),
        .warm_rst_n   (warm_rst_n),
        .evt_cold_req (evt_cold_req),
        .evt_warm_req (evt_warm_req),
        .evt_last_por (evt_last_por),
        .evt_wdog     (evt_wdog),
        .evt_debug    (evt_debug),
        .evt_dap      (evt_dap),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data)
    );

    task automatic drive(input logic [9:0] evt, input logic wr, input logic [31:0] wd);
        {evt_dap, evt_debug, evt_wdog, evt_last_por, evt_warm_req, evt_cold_req} = evt;
        wr_en   = wr;
        wr_data = wd;
    endtask

    task automatic chk(input int req, input logic [31:0] exp, input string what);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, rd_data, exp);
        end
    endtask

    // Drive one cycle of inputs, let one rising edge pass, then return to idle.
    task automatic step(input logic [9:0] evt, input logic wr, input logic [31:0] wd);
        drive(evt, wr, wd);
        @(negedge clk);
        drive('0, 1'b0, '0);
    endtask

    initial begin
        por_rst_n  = 1'b0;
        cold_rst_n = 1'b1;
        warm_rst_n = 1'b1;
        drive('0, 1'b0, '0);
        repeat (3) @(negedge clk);
        chk(1, 32'h0000_0004, "power-on value");              // R1
        por_rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].evt, VEC[i].wr, VEC[i].wd);
            @(negedge clk);
            chk(int'(VEC[i].req), VEC[i].exp, $sformatf("vector %0d", i));
        end
        drive('0, 1'b0, '0);

        // Set every flag; state before is 0x2.
        step(10'h3FF, 1'b0, '0);
        chk(2, 32'h031F_0007, "all sources");                 // R2
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(10, 32'h031F_0007, "idle read hold");         // R10
        end

        warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        warm_rst_n = 1'b1;
        chk(8, 32'h031F_0007, "warm reset keeps flags");      // R8

        cold_rst_n = 1'b0;
        @(negedge clk);
        cold_rst_n = 1'b1;
        chk(6, 32'h0300_0005, "cold reset split");            // R6

        por_rst_n = 1'b0;
        @(negedge clk);
        por_rst_n = 1'b1;
        chk(7, 32'h0000_0004, "power-on from mixed state");   // R7

        step('0, 1'b1, 32'h0000_0004);
        chk(4, 32'h0000_0000, "clear last por flag");         // R4
        cold_rst_n = 1'b0;
        @(negedge clk);
        cold_rst_n = 1'b1;
        chk(6, 32'h0000_0000, "cold keeps cleared last por"); // R6

        por_rst_n = 1'b0;
        @(negedge clk);
        por_rst_n = 1'b1;
        chk(1, 32'h0000_0004, "last por set again");          // R1
        @(negedge clk);
        chk(1, 32'h0000_0004, "after power-on release");      // R1

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule